// File: doc/BRIEF.md
# Cascadable Reload Timer Channel

This block is one channel of a bank of 16-bit up-counting timers. It holds a counter, a reload value and a small control byte. Once running, the counter advances on each tick from the source that the control byte picks. That source is either one of four rate strobes, which a shared prescaler outside the block produces, or the overflow pulse of the channel in front of it. When the counter passes its top value it restarts from the reload value rather than from zero. The block then pulses its overflow output, and also its interrupt request output if that is enabled. The overflow output feeds the chain input of the following channel, so channels can be joined into wider counters.

Writes to the reload value and to the control byte arrive as a strobe with data, and both take effect one cycle late. A write to the reload value never touches the live counter. The counter picks up the reload value only when the run bit goes from 0 to 1, and on every wrap. The `CHAIN_OK` parameter builds a head-of-chain variant. In that variant the chain select bit is ignored and the channel always counts rate strobes.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `count_o` is 0, `ovf_o` and `irq_o` are low, the stored reload value is 0 and the stored control byte is 0 (stopped).
- R2: A reload write changes only the stored reload value. `count_o` always shows the live counter and does not move on such a write.
- R3: Control bit 7 is the run bit. In the cycle a 0-to-1 change of the run bit takes effect, the counter is loaded with the reload value in effect and does not count.
- R4: While running, the counter rises by exactly one on each tick of the selected source and holds on cycles with no tick.
- R5: With control bit 2 clear, control bits 1:0 (code 0 to 3) pick `rate_tick[code]`. By convention the prescaler drives these strobes once every 1, 64, 256 and 1024 clocks.
- R6: With control bit 2 set, the tick source is `chain_in`, the previous channel's overflow pulse.
- R7: A tick at count 0xFFFF loads the reload value in effect instead of wrapping to zero. `ovf_o` is high for exactly the following cycle.
- R8: `irq_o` pulses together with `ovf_o` exactly when control bit 6 was set at the wrap, and is never high otherwise.
- R9: A write strobe sampled on clock edge k is applied on edge k+1 and not before. On edge k+1 it already acts for loading, counting and wrapping.
- R10: While the run bit in effect is 0, the counter holds its value and no overflow or interrupt pulse occurs.
- R11: With a reload value of 0xFFFF and a tick every clock, the channel overflows on every tick.
- R12: With `CHAIN_OK` = 0 the channel ignores control bit 2 and always counts `rate_tick[code]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_tick | input | 4 | Prescaler strobes, one per rate code |
| chain_in | input | 1 | Overflow pulse of the previous channel |
| reload_we | input | 1 | Reload value write strobe |
| reload_wdata | input | 16 | Reload value write data |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte: [7] run, [6] irq enable, [2] chain select, [1:0] rate code |
| count_o | output | 16 | Live counter value |
| ovf_o | output | 1 | One-cycle overflow pulse |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The hardest case to reach is a staged write that lands on the same edge as a wrap or a run start. The bench walks the counter to 0xFFFE and issues a reload write right then. The staged value must be the one picked up by the wrap one edge later. It also writes the reload value and the run bit in one cycle, and the load must use the new value. A behavioural model that keeps its own pending-write variables is compared with both a chaining instance and a head-of-chain instance on every clock. A chain-driven phase then shows the two instances moving apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int RATE_W  = 2;
  localparam int N_RATES = 1 << RATE_W;

  // Field positions are fixed: software writes this byte directly.
  typedef struct packed {
    logic              run;     // bit 7
    logic              irq_en;  // bit 6
    logic [2:0]        rsvd;    // bits 5:3
    logic              chain;   // bit 2
    logic [RATE_W-1:0] rate;    // bits 1:0
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_wr_stage.sv
module tmr_wr_stage
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_wdata,
  input  logic             ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CNT_W-1:0] reload_eff,
  output tmr_ctrl_t        ctrl_eff,
  output logic             run_prev
);
  logic [CNT_W-1:0] rl_pend, rl_q;
  logic             rl_pend_v;
  tmr_ctrl_t        ct_pend, ct_q;
  logic             ct_pend_v;

  // A staged write is what applies on the edge after its strobe.
  assign reload_eff = rl_pend_v ? rl_pend : rl_q;
  assign ctrl_eff   = ct_pend_v ? ct_pend : ct_q;
  assign run_prev   = ct_q.run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl_pend   <= '0;
      rl_pend_v <= 1'b0;
      rl_q      <= '0;
      ct_pend   <= '0;
      ct_pend_v <= 1'b0;
      ct_q      <= '0;
    end else begin
      rl_pend_v <= reload_we;
      if (reload_we) rl_pend <= reload_wdata;
      rl_q      <= reload_eff;
      ct_pend_v <= ctrl_we;
      if (ctrl_we) ct_pend <= tmr_ctrl_t'(ctrl_wdata);
      ct_q      <= ctrl_eff;
    end
  end

  // R9: a write is visible to the channel exactly one edge later
  a_r9_reload_late: assert property (@(posedge clk) disable iff (!rst_n)
    reload_we |=> (reload_eff == $past(reload_wdata)));
  a_r9_ctrl_late: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_eff == $past(ctrl_wdata)));
  // R2: with no write pending the reload value does not drift
  a_r2_reload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_we && !rl_pend_v) |=> $stable(reload_eff));
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
#(
  parameter bit CHAIN_OK = 1'b1
) (
  input  logic [N_RATES-1:0] rate_tick,
  input  logic               chain_in,
  input  logic               chain_sel,
  input  logic [RATE_W-1:0]  rate_code,
  output logic               tick
);
  logic rate_pick;
  assign rate_pick = rate_tick[rate_code];

  generate
    if (CHAIN_OK) begin : g_chain
      assign tick = chain_sel ? chain_in : rate_pick;
    end else begin : g_head
      logic unused_chain;
      assign unused_chain = chain_in ^ chain_sel;
      assign tick = rate_pick;
    end
  endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_now,
  input  logic             run_prev,
  input  logic             tick,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             irq,
  output logic             start_evt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return v == TOP;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, irq_q;
  logic             step_evt;

  // A start takes priority over a tick on the same edge.
  assign start_evt = run_now & ~run_prev;
  assign step_evt  = run_now & tick & ~start_evt;
  assign wrap_evt  = step_evt & at_top(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovf_q <= wrap_evt;
      irq_q <= wrap_evt & irq_en;
      if (start_evt || wrap_evt) cnt_q <= reload_val;
      else if (step_evt)         cnt_q <= bump(cnt_q);
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
  assign irq   = irq_q;

  // R3: a start loads the reload value
  a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt_q == $past(reload_val)));
  // R4: a plain step adds one
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && tick && run_prev && !at_top(cnt_q)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));
  // R7: an overflow pulse comes with the reload value in the counter
  a_r7_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == $past(reload_val)));
  // R8: interrupt only alongside overflow
  a_r8_irq_with_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ovf_q);
  // R10: stopped means frozen and silent
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_now |=> ($stable(cnt_q) && !ovf_q && !irq_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit CHAIN_OK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RATES-1:0] rate_tick,
  input  logic               chain_in,
  input  logic               reload_we,
  input  logic [CNT_W-1:0]   reload_wdata,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  output logic [CNT_W-1:0]   count_o,
  output logic               ovf_o,
  output logic               irq_o
);
  logic [CNT_W-1:0] reload_eff;
  tmr_ctrl_t        ctrl_eff;
  logic             run_prev;
  logic             tick;
  logic             start_evt, wrap_evt;
  logic             unused_rsvd;

  assign unused_rsvd = ^ctrl_eff.rsvd;

  tmr_wr_stage #(.CNT_W(CNT_W)) u_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .reload_we    (reload_we),
    .reload_wdata (reload_wdata),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .reload_eff   (reload_eff),
    .ctrl_eff     (ctrl_eff),
    .run_prev     (run_prev)
  );

  tmr_tick_sel #(.CHAIN_OK(CHAIN_OK)) u_sel (
    .rate_tick (rate_tick),
    .chain_in  (chain_in),
    .chain_sel (ctrl_eff.chain),
    .rate_code (ctrl_eff.rate),
    .tick      (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_now    (ctrl_eff.run),
    .run_prev   (run_prev),
    .tick       (tick),
    .irq_en     (ctrl_eff.irq_en),
    .reload_val (reload_eff),
    .count      (count_o),
    .ovf        (ovf_o),
    .irq        (irq_o),
    .start_evt  (start_evt),
    .wrap_evt   (wrap_evt)
  );

  // R7: the overflow pulse follows a wrap event and nothing else
  a_r7_ovf_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(wrap_evt));
  // R3: a start never produces an overflow on the next cycle
  a_r3_start_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !ovf_o);
endmodule

// File: tb/tb_tmr_channel.sv
module tmr_ref #(
  parameter bit HEAD = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rate_tick,
  input  logic        chain_in,
  input  logic        reload_we,
  input  logic [15:0] reload_wdata,
  input  logic        ctrl_we,
  input  logic [7:0]  ctrl_wdata,
  output int          m_cnt,
  output bit          m_ovf,
  output bit          m_irq
);
  int rl_cur, rl_new, ct_cur, ct_new;
  bit rl_has, ct_has;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ovf = 0; m_irq = 0;
      rl_cur = 0; rl_new = 0; ct_cur = 0; ct_new = 0;
      rl_has = 0; ct_has = 0;
    end else begin
      int ctl;
      int rl;
      bit src;
      ctl = ct_has ? ct_new : ct_cur;
      rl  = rl_has ? rl_new : rl_cur;
      m_ovf = 0;
      m_irq = 0;
      if (ctl[7] && !ct_cur[7]) begin
        m_cnt = rl;
      end else if (ctl[7]) begin
        src = (ctl[2] && !HEAD) ? chain_in : rate_tick[ctl[1:0]];
        if (src) begin
          if (m_cnt == 65535) begin
            m_cnt = rl; m_ovf = 1; m_irq = ctl[6];
          end else begin
            m_cnt = m_cnt + 1;
          end
        end
      end
      ct_cur = ctl; rl_cur = rl;
      ct_has = ctrl_we;   ct_new = int'(ctrl_wdata);
      rl_has = reload_we; rl_new = int'(reload_wdata);
    end
  end
endmodule

module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rate_tick = 4'b0001;
  logic        chain_in = 1'b0;
  logic        reload_we = 1'b0;
  logic [15:0] reload_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [15:0] count_o, h_count;
  logic        ovf_o, irq_o, h_ovf, h_irq;
  int          e_cnt, eh_cnt;
  bit          e_ovf, e_irq, eh_ovf, eh_irq;

  int    nchk = 0;
  int    nerr = 0;
  int    cyc = 0;
  string phase = "R1";
  int    held;

  always #5 clk = ~clk;

  tmr_channel #(.CNT_W(16), .CHAIN_OK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .chain_in(chain_in),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .count_o(count_o), .ovf_o(ovf_o), .irq_o(irq_o));

  tmr_channel #(.CNT_W(16), .CHAIN_OK(1'b0)) dut_head (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .chain_in(chain_in),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .count_o(h_count), .ovf_o(h_ovf), .irq_o(h_irq));

  tmr_ref #(.HEAD(1'b0)) ref_main (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .chain_in(chain_in),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .m_cnt(e_cnt), .m_ovf(e_ovf), .m_irq(e_irq));

  tmr_ref #(.HEAD(1'b1)) ref_head (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .chain_in(chain_in),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .m_cnt(eh_cnt), .m_ovf(eh_ovf), .m_irq(eh_irq));

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Rate strobes: code k fires once every 1, 64, 256, 1024 clocks.
  function automatic int period(input int k);
    return (k == 0) ? 1 : (1 << (2 * k + 4));
  endfunction

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 4; k++) rate_tick[k] <= ((cyc % period(k)) == 0);
  end

  // Per-cycle comparison against the behavioural model.
  always @(negedge clk) begin
    if (rst_n) begin
      check(phase, "count", int'(count_o), e_cnt);
      check(phase, "ovf", int'(ovf_o), int'(e_ovf));
      check(phase, "irq", int'(irq_o), int'(e_irq));
      check("R12", "head count", int'(h_count), eh_cnt);
      check("R12", "head ovf", int'(h_ovf), int'(eh_ovf));
      check("R12", "head irq", int'(h_irq), int'(eh_irq));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_rl(input logic [15:0] d);
    reload_we = 1'b1; reload_wdata = d;
    @(negedge clk);
    reload_we = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", "reset count", int'(count_o), 0);
    check("R1", "reset ovf", int'(ovf_o), 0);
    check("R1", "reset irq", int'(irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R2";
    wr_rl(16'h1234);
    repeat (3) @(negedge clk);
    check("R2", "count after reload write", int'(count_o), 0);

    phase = "R3";
    wr_ctrl(8'h80);
    check("R9", "count before apply", int'(count_o), 0);
    @(negedge clk);
    check("R3", "count after start", int'(count_o), 16'h1234);
    phase = "R4";
    @(negedge clk);
    check("R4", "first step", int'(count_o), 16'h1235);
    @(negedge clk);
    check("R4", "second step", int'(count_o), 16'h1236);

    phase = "R10";
    wr_ctrl(8'h00);
    @(negedge clk);
    check("R9", "last count before stop", int'(count_o), 16'h1237);
    held = int'(count_o);
    repeat (6) @(negedge clk);
    check("R10", "held count", int'(count_o), held);
    check("R10", "no ovf when stopped", int'(ovf_o), 0);

    phase = "R7";
    wr_rl(16'hFFF0);
    wr_ctrl(8'hC0);
    @(negedge clk);
    check("R3", "start at FFF0", int'(count_o), 16'hFFF0);
    repeat (15) @(negedge clk);
    check("R7", "at top", int'(count_o), 16'hFFFF);
    check("R7", "no ovf yet", int'(ovf_o), 0);
    @(negedge clk);
    check("R7", "wrap to reload", int'(count_o), 16'hFFF0);
    check("R7", "ovf pulse", int'(ovf_o), 1);
    check("R8", "irq pulse", int'(irq_o), 1);
    @(negedge clk);
    check("R7", "ovf single cycle", int'(ovf_o), 0);
    check("R8", "irq single cycle", int'(irq_o), 0);

    phase = "R11";
    wr_ctrl(8'h80);
    wr_rl(16'hFFFF);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check("R11", "ovf every tick", int'(ovf_o), 1);
      check("R8", "irq disabled", int'(irq_o), 0);
      check("R11", "count stays top", int'(count_o), 16'hFFFF);
      @(negedge clk);
    end

    wr_ctrl(8'h00);
    wr_rl(16'h0000);
    @(negedge clk);
    phase = "R5";
    for (int code = 1; code < 4; code++) begin
      wr_ctrl(8'h80 | 8'(code));
      repeat (1100) @(negedge clk);
      wr_ctrl(8'h00);
      @(negedge clk);
    end

    phase = "R6";
    wr_rl(16'h0100);
    wr_ctrl(8'h84);
    @(negedge clk);
    check("R6", "chain start", int'(count_o), 16'h0100);
    for (int i = 0; i < 5; i++) begin
      chain_in = 1'b1;
      @(negedge clk);
      chain_in = 1'b0;
      @(negedge clk);
    end
    check("R6", "counted chain pulses", int'(count_o), 16'h0105);
    check("R12", "head ignores chain select", int'(h_count), 16'h010A);

    phase = "R9";
    wr_ctrl(8'h00);
    @(negedge clk);
    held = int'(count_o);
    reload_we = 1'b1; reload_wdata = 16'h0AAA;
    ctrl_we = 1'b1;   ctrl_wdata = 8'hC0;
    @(negedge clk);
    reload_we = 1'b0; ctrl_we = 1'b0;
    check("R9", "no effect on strobe edge", int'(count_o), held);
    @(negedge clk);
    check("R3", "start uses fresh reload", int'(count_o), 16'h0AAA);

    wr_ctrl(8'h00);
    wr_rl(16'hFFFC);
    wr_ctrl(8'h80);
    @(negedge clk);
    check("R3", "start at FFFC", int'(count_o), 16'hFFFC);
    repeat (2) @(negedge clk);
    check("R4", "at FFFE", int'(count_o), 16'hFFFE);
    wr_rl(16'h0500);
    check("R9", "top before wrap", int'(count_o), 16'hFFFF);
    @(negedge clk);
    check("R9", "wrap uses staged reload", int'(count_o), 16'h0500);
    check("R7", "ovf on staged wrap", int'(ovf_o), 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule